// File: doc/BRIEF.md
# PWM Buffered Update Lockout Bank

This block holds the values a PWM generator runs from: four duty-cycle values and one period value. Each has two copies. The buffer copy is written from a simple register bus. The active copy drives the generator. A period-boundary strobe comes in from the PWM time base. On each strobe the active copies reload from the buffers.

Software can set a single lockout bit, which covers all five values. While the lockout is set, bus writes still land in the buffers, but no strobe moves them to the active copies. Clearing the lockout copies every buffer into its active register on the same edge. A group of related values therefore takes effect together. The intended sequence is: set the lockout, write the buffers that need to change, then clear the lockout.

Top module: `pwmlk_update_bank`

## Requirements
- R1: Bus writes (`wr_en` high) go to duty buffer n at address n (0 to 3) and to the period buffer at address 4. Address 5 is the control register. Writes to addresses 6 and 7 change nothing.
- R2: A buffer write leaves every active value unchanged until a transfer occurs.
- R3: Bit 0 of a control write sets (1) or clears (0) the lockout. While the lockout is set, no active value changes, however many strobes arrive, unless the write is a release.
- R4: A control write with bit 0 clear while the lockout is set loads all five buffers into the active registers on that clock edge. The new values are visible in the following cycle.
- R5: A control write with bit 0 clear while the lockout is already clear causes no transfer.
- R6: With the lockout clear, a high `period_strobe` loads all five buffers into the active registers on that edge.
- R7: When a buffer write and a transfer occur in the same cycle, the active register receives the newly written value.
- R8: After reset, all buffers and all active values are zero and the lockout is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W (3) | Bus write address |
| wr_data | input | DATA_W (16) | Bus write data |
| period_strobe | input | 1 | Period-boundary pulse from the PWM time base |
| duty_o | output | NUM_DUTY*DATA_W (64) | Active duty values; duty n is in bits [16n+15:16n] |
| period_o | output | DATA_W (16) | Active period value |

## Verification
The bench builds the block with its defaults: four duty channels, 16-bit values and a 3-bit address. This small address space lets every address be swept, including the two unused ones. The 16-bit values can be given distinct computed patterns per channel and round, so a value that goes to the wrong channel or arrives from the wrong round shows up. Several lockout rounds apply multiple strobes before each release. The bench also covers a partial update, a redundant release, and a write in the same cycle as a strobe.

// File: rtl/pwmlk_pkg.sv
package pwmlk_pkg;
   // bit of the control word that holds the lockout flag
   localparam int unsigned LOCK_BIT = 0;

   function automatic int unsigned ctrl_index(input int unsigned n_duty);
      return n_duty + 1;
   endfunction

   function automatic int unsigned period_index(input int unsigned n_duty);
      return n_duty;
   endfunction
endpackage

// File: rtl/pwmlk_lock_ctrl.sv
module pwmlk_lock_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_hit,
   input  logic ctrl_bit,
   input  logic strobe,
   output logic lock_q,
   output logic xfer
);
   logic release_now;

   assign release_now = ctrl_hit & lock_q & ~ctrl_bit;
   assign xfer        = release_now | (~lock_q & strobe);

   always_ff @(posedge clk) begin
      if (!rst_n)        lock_q <= 1'b0;
      else if (ctrl_hit) lock_q <= ctrl_bit;
   end
endmodule

// File: rtl/pwmlk_shadow_reg.sv
module pwmlk_shadow_reg #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              xfer,
   output logic [DATA_W-1:0] buf_q,
   output logic [DATA_W-1:0] act_q
);
   logic [DATA_W-1:0] buf_nxt;

   // a write in the transfer cycle is forwarded to the active copy
   assign buf_nxt = wr_hit ? wr_data : buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q <= '0;
         act_q <= '0;
      end else begin
         buf_q <= buf_nxt;
         if (xfer) act_q <= buf_nxt;
      end
   end
endmodule

// File: rtl/pwmlk_update_bank.sv
module pwmlk_update_bank #(
   parameter int unsigned NUM_DUTY = 4,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         period_strobe,
   output logic [NUM_DUTY*DATA_W-1:0]   duty_o,
   output logic [DATA_W-1:0]            period_o
);
   import pwmlk_pkg::*;

   localparam int unsigned NUM_CH   = NUM_DUTY + 1;
   localparam int unsigned PER_IDX  = period_index(NUM_DUTY);
   localparam int unsigned CTRL_IDX = ctrl_index(NUM_DUTY);
   localparam int unsigned MIN_AW   = $clog2(CTRL_IDX + 1);

   generate
      if (NUM_DUTY < 1)      $error("NUM_DUTY must be at least 1");
      if (DATA_W < 2)        $error("DATA_W must be at least 2");
      if (ADDR_W < MIN_AW)   $error("ADDR_W too small for register map");
   endgenerate

   logic                       lock_q;
   logic                       xfer;
   logic                       ctrl_hit;
   logic [NUM_CH*DATA_W-1:0]   buf_flat;
   logic [NUM_CH*DATA_W-1:0]   act_flat;

   assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_IDX));

   pwmlk_lock_ctrl u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_hit (ctrl_hit),
      .ctrl_bit (wr_data[LOCK_BIT]),
      .strobe   (period_strobe),
      .lock_q   (lock_q),
      .xfer     (xfer)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(g));
      pwmlk_shadow_reg #(.DATA_W(DATA_W)) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (hit),
         .wr_data (wr_data),
         .xfer    (xfer),
         .buf_q   (buf_flat[g*DATA_W +: DATA_W]),
         .act_q   (act_flat[g*DATA_W +: DATA_W])
      );
      if (g == PER_IDX) begin : g_per
         assign period_o = act_flat[g*DATA_W +: DATA_W];
      end else begin : g_duty
         assign duty_o[g*DATA_W +: DATA_W] = act_flat[g*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/pwmlk_update_bank_chk.sv
module pwmlk_update_bank_chk #(
   parameter int unsigned NUM_DUTY = 4,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_en,
   input logic [ADDR_W-1:0]              wr_addr,
   input logic [DATA_W-1:0]              wr_data,
   input logic                           period_strobe,
   input logic [NUM_DUTY*DATA_W-1:0]     duty_o,
   input logic [DATA_W-1:0]              period_o,
   input logic                           lock_q,
   input logic [(NUM_DUTY+1)*DATA_W-1:0] buf_flat
);
   logic rel_wr;
   logic per_wr;
   assign rel_wr = wr_en && (wr_addr == ADDR_W'(NUM_DUTY + 1)) && !wr_data[0];
   assign per_wr = wr_en && (wr_addr == ADDR_W'(NUM_DUTY));

   // R3
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !rel_wr) |=> ($stable(duty_o) && $stable(period_o)));

   // R4
   release_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && rel_wr) |=> ({period_o, duty_o} == $past(buf_flat)));

   // R7
   fwd_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_q && period_strobe && per_wr) |=> (period_o == $past(wr_data)));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_q && !period_strobe) |=> ($stable(duty_o) && $stable(period_o)));
endmodule

bind pwmlk_update_bank pwmlk_update_bank_chk #(
   .NUM_DUTY(NUM_DUTY), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .period_strobe(period_strobe), .duty_o(duty_o),
   .period_o(period_o), .lock_q(lock_q), .buf_flat(buf_flat)
);

// File: tb/pwmlk_update_bank_tb_top.sv
module pwmlk_update_bank_tb_top;
   localparam int ND = 4;
   localparam int DW = 16;
   localparam int AW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [DW-1:0]   wr_data = '0;
   logic            period_strobe = 1'b0;
   logic [ND*DW-1:0] duty_o;
   logic [DW-1:0]   period_o;

   int total = 0;
   int bad = 0;
   logic [DW-1:0] bufm [ND+1];
   logic [DW-1:0] actm [ND+1];
   logic lockm = 1'b0;

   always #10 clk = ~clk;

   pwmlk_update_bank #(.NUM_DUTY(ND), .DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .period_strobe(period_strobe),
      .duty_o(duty_o), .period_o(period_o)
   );

   function automatic logic [DW-1:0] pat(input int r, input int ch);
      return DW'((r * 16'h1357 + ch * 16'h0F0F + 16'h0101) & 16'hFFFF);
   endfunction

   task automatic check_all(input string req);
      for (int c = 0; c <= ND; c++) begin
         logic [DW-1:0] got;
         got = (c == ND) ? period_o : duty_o[c*DW +: DW];
         total++;
         if (got !== actm[c]) begin
            bad++;
            $display("FAIL %s ch%0d actual=%h expected=%h", req, c, got, actm[c]);
         end
      end
   endtask

   task automatic model_xfer();
      for (int c = 0; c <= ND; c++) actm[c] = bufm[c];
   endtask

   // one bus cycle, optionally with a strobe in the same cycle
   task automatic cyc(input logic we, input int a, input logic [DW-1:0] d, input logic stb);
      logic do_x;
      @(negedge clk);
      wr_en = we; wr_addr = AW'(a); wr_data = d; period_strobe = stb;
      @(negedge clk);
      wr_en = 1'b0; period_strobe = 1'b0;
      if (we && a < ND + 1) bufm[a] = d;
      do_x = (we && a == ND + 1 && lockm && !d[0]) || (!lockm && stb);
      if (do_x) model_xfer();
      if (we && a == ND + 1) lockm = d[0];
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int c = 0; c <= ND; c++) begin bufm[c] = '0; actm[c] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R8");

      // R1 R2: fill buffers, nothing moves before a strobe
      for (int c = 0; c <= ND; c++) cyc(1'b1, c, pat(1, c), 1'b0);
      check_all("R2");
      cyc(1'b0, 0, '0, 1'b1);
      check_all("R6");

      // R3 R4: several lockout rounds, three strobes each
      for (int r = 2; r < 6; r++) begin
         cyc(1'b1, ND + 1, 16'h0001, 1'b0);
         for (int c = 0; c <= ND; c++) cyc(1'b1, c, pat(r, c), 1'b0);
         for (int s = 0; s < 3; s++) begin
            cyc(1'b0, 0, '0, 1'b1);
            check_all("R3");
         end
         cyc(1'b1, ND + 1, 16'h0000, 1'b0);
         check_all("R4");
      end

      // R4: partial group under lockout
      cyc(1'b1, ND + 1, 16'h0001, 1'b0);
      cyc(1'b1, 2, 16'hBEEF, 1'b1);
      check_all("R3");
      cyc(1'b1, ND + 1, 16'h0000, 1'b0);
      check_all("R4");

      // R5: redundant release moves nothing
      cyc(1'b1, 1, 16'h4242, 1'b0);
      cyc(1'b1, ND, 16'h0777, 1'b0);
      cyc(1'b1, ND + 1, 16'h0000, 1'b0);
      check_all("R5");
      cyc(1'b0, 0, '0, 1'b1);
      check_all("R6");

      // R7: write and strobe together, each channel
      for (int c = 0; c <= ND; c++) begin
         cyc(1'b1, c, pat(9, c) ^ 16'hA5A5, 1'b1);
         check_all("R7");
      end

      // R1: unused addresses are ignored
      for (int a = ND + 2; a < (1 << AW); a++) begin
         cyc(1'b1, a, 16'hFFFF, 1'b0);
         cyc(1'b0, 0, '0, 1'b1);
         check_all("R1");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule